// File: doc/BRIEF.md
# Configuration Block Fetch Sequencer

The block is a bus master that copies a small configuration structure from host memory into a local register file. A one-cycle start command supplies a DWord-aligned base address. The sequencer then requests the bus, waits for a grant and performs exactly two single-DWord reads in that tenure. It then releases the bus and requests it again for the next tenure, continuing from the address where the previous tenure stopped.

Two structure sizes are supported. The wide layout needs seven DWords and is fetched in four tenures. The last read of the final tenure lands on an unused location, and its data is thrown away. The narrow layout is fetched in three tenures, and all six DWords are kept. A burst select chooses how each tenure is framed. In non-burst mode every read has its own address phase, and the frame is dropped between the two reads. In burst mode a single address phase, with the two low address bits at zero to signal linear order, covers both data beats.

A busy flag covers the whole run, and a done pulse marks its end. The fetched words are read back through a combinational index port. Both mode inputs are captured at start.

Top module: `ib_fetch_seq`

## Requirements
- R1: After reset busy_o, done_o, req_o, frame_o and aphase_o are 0 and every register file entry reads 0.
- R2: Each tenure raises req_o, waits for gnt_i, completes exactly two data beats (a beat is a cycle with frame_o=1, aphase_o=0, rvalid_i=1), and then drops req_o for at least one cycle; frame_o is only high while req_o and gnt_i are high.
- R3: With wide_i=1 at start, four tenures are run, and entry i (i = 0..6) holds the DWord read from base+4*i.
- R4: In wide mode the eighth read (address base+28) is performed, but its data is discarded; entry 7 keeps its previous value.
- R5: With wide_i=0 at start, three tenures are run, entries 0..5 hold the DWords from base+4*i, and entries 6 and 7 are unchanged.
- R6: With burst_i=0, every beat is preceded by its own one-cycle address phase, and frame_o is low for exactly one cycle (req_o still high) between the two beats of a tenure.
- R7: With burst_i=1, each tenure has one address phase with addr_o[1:0]=00, and frame_o stays high across both beats.
- R8: Address phases carry base+4*k for the k-th phase in non-burst mode and base+8*k in burst mode, so each tenure continues contiguously.
- R9: busy_o is high from the cycle after start until done_o; done_o is a one-cycle pulse in the cycle after the final beat, with busy_o low.
- R10: start_i while busy_o is high is ignored; the run continues with its original base and modes.
- R11: rd_data_o shows entry rd_idx_i combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle start command |
| base_i | input | ADDR_W | DWord-aligned base address of the structure |
| wide_i | input | 1 | 1: seven-DWord layout, 0: six-DWord layout |
| burst_i | input | 1 | 1: burst tenures, 0: one address phase per beat |
| busy_o | output | 1 | Fetch in progress |
| done_o | output | 1 | One-cycle completion pulse |
| req_o | output | 1 | Bus request |
| gnt_i | input | 1 | Bus grant |
| frame_o | output | 1 | Transfer frame valid |
| aphase_o | output | 1 | Address phase, addr_o valid |
| addr_o | output | ADDR_W | Transfer address |
| rvalid_i | input | 1 | Read data valid in a data phase |
| rdata_i | input | DATA_W | Read data |
| rd_idx_i | input | IW | Register file read index |
| rd_data_o | output | DATA_W | Register file read data |

## Verification
The assertions assume a well-behaved bus partner. Once the grant is given, it holds gnt_i high for as long as req_o stays high. It raises rvalid_i only in data phases. The base address is DWord-aligned, so address low bits are zero in every address phase. The bench's bus model gives the grant only in response to a request and holds it until the request falls. It returns data only while the frame is up outside an address phase, and it inserts grant delays and wait states without breaking these rules. Every base it uses is a multiple of four.

// File: rtl/ibf_pkg.sv
package ibf_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_ADDR,
    S_DATA,
    S_GAP,
    S_REL
  } ibf_state_e;
endpackage

// File: rtl/ibf_ctrl.sv
module ibf_ctrl
  import ibf_pkg::*;
#(
  parameter int TEN_WIDE   = 4,
  parameter int TEN_NARROW = 3,
  parameter int WORDS_WIDE = 7,
  parameter int CW         = $clog2(2*TEN_WIDE+1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          wide_i,
  input  logic          burst_i,
  input  logic          gnt_i,
  input  logic          rvalid_i,
  output logic          req_o,
  output logic          frame_o,
  output logic          aphase_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          load_o,
  output logic          accept_o,
  output logic          store_o,
  output logic          burst_q_o,
  output logic [CW-1:0] idx_o
);
  localparam logic [CW-1:0] LAST_WIDE   = CW'(2*TEN_WIDE - 1);
  localparam logic [CW-1:0] LAST_NARROW = CW'(2*TEN_NARROW - 1);
  localparam logic [CW-1:0] KEEP_WIDE   = CW'(WORDS_WIDE);
  localparam logic [CW-1:0] KEEP_NARROW = CW'(2*TEN_NARROW);

  ibf_state_e state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic wide_q, burst_q, beat_q, done_q;
  logic last_beat;

  assign accept_o  = (state_q == S_DATA) && rvalid_i;
  assign last_beat = accept_o && (cnt_q == (wide_q ? LAST_WIDE : LAST_NARROW));
  // surplus reads still run on the bus but are not written
  assign store_o   = accept_o && (cnt_q < (wide_q ? KEEP_WIDE : KEEP_NARROW));
  assign load_o    = (state_q == S_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (start_i) state_d = S_REQ;
      S_REQ:  if (gnt_i) state_d = S_ADDR;
      S_ADDR: state_d = S_DATA;
      S_DATA: if (accept_o) begin
        if (last_beat)      state_d = S_IDLE;
        else if (beat_q)    state_d = S_REL;
        else if (!burst_q)  state_d = S_GAP;
      end
      S_GAP:  state_d = S_ADDR;
      S_REL:  state_d = S_REQ;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      wide_q  <= 1'b0;
      burst_q <= 1'b0;
      beat_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= last_beat;
      if (load_o) begin
        cnt_q   <= '0;
        wide_q  <= wide_i;
        burst_q <= burst_i;
        beat_q  <= 1'b0;
      end else if (accept_o) begin
        cnt_q  <= cnt_q + 1'b1;
        beat_q <= ~beat_q;
      end
    end
  end

  assign req_o     = (state_q == S_REQ) || (state_q == S_ADDR) ||
                     (state_q == S_DATA) || (state_q == S_GAP);
  assign frame_o   = (state_q == S_ADDR) || (state_q == S_DATA);
  assign aphase_o  = (state_q == S_ADDR);
  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = done_q;
  assign burst_q_o = burst_q;
  assign idx_o     = cnt_q;
endmodule

// File: rtl/ibf_addr_gen.sv
module ibf_addr_gen #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              accept_i,
  input  logic              burst_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       addr_q <= '0;
    else if (load_i)   addr_q <= base_i;
    else if (accept_i) addr_q <= addr_q + STEP;
  end

  // burst address phase signals linear order through zero low bits
  assign addr_o = burst_i ? {addr_q[ADDR_W-1:2], 2'b00} : addr_q;
endmodule

// File: rtl/ibf_regfile.sv
module ibf_regfile #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int IW     = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IW-1:0]     widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IW-1:0]     ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         mem_q[g] <= '0;
      else if (we_i && widx_i == IW'(g))   mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/ib_fetch_seq.sv
module ib_fetch_seq #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int TEN_WIDE   = 4,
  parameter int TEN_NARROW = 3,
  parameter int WORDS_WIDE = 7,
  parameter int DEPTH      = 2*TEN_WIDE,
  parameter int IW         = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              wide_i,
  input  logic              burst_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              req_o,
  input  logic              gnt_i,
  output logic              frame_o,
  output logic              aphase_o,
  output logic [ADDR_W-1:0] addr_o,
  input  logic              rvalid_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [IW-1:0]     rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int CW = $clog2(2*TEN_WIDE+1);

  logic          load, accept, store, burst_q;
  logic [CW-1:0] idx;

  ibf_ctrl #(
    .TEN_WIDE(TEN_WIDE), .TEN_NARROW(TEN_NARROW),
    .WORDS_WIDE(WORDS_WIDE), .CW(CW)
  ) u_ctrl (
    .clk_i, .rst_ni, .start_i, .wide_i, .burst_i, .gnt_i, .rvalid_i,
    .req_o, .frame_o, .aphase_o, .busy_o, .done_o,
    .load_o(load), .accept_o(accept), .store_o(store),
    .burst_q_o(burst_q), .idx_o(idx)
  );

  ibf_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i, .rst_ni, .load_i(load), .base_i, .accept_i(accept),
    .burst_i(burst_q), .addr_o
  );

  ibf_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IW(IW)) u_rf (
    .clk_i, .rst_ni, .we_i(store), .widx_i(idx[IW-1:0]), .wdata_i(rdata_i),
    .ridx_i(rd_idx_i), .rdata_o(rd_data_o)
  );
endmodule

// File: rtl/ib_fetch_seq_chk.sv
module ib_fetch_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              req_o,
  input logic              gnt_i,
  input logic              frame_o,
  input logic              aphase_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              rvalid_i
);
  logic [1:0] beats_q;
  logic beat;
  assign beat = frame_o && !aphase_o && rvalid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    beats_q <= '0;
    else if (!req_o) beats_q <= '0;
    else if (beat)   beats_q <= beats_q + 1'b1;
  end

  assert_frame_granted_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> (req_o && gnt_i));
  assert_two_beats_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat |-> (beats_q < 2'd2));
  assert_gap_then_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !frame_o && beats_q == 2'd1) |=> aphase_o);
  assert_linear_lowbits_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aphase_o |-> (addr_o[1:0] == 2'b00));
  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_req_in_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> busy_o);
  assert_busy_from_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
endmodule

bind ib_fetch_seq ib_fetch_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .start_i, .busy_o, .done_o, .req_o, .gnt_i,
  .frame_o, .aphase_o, .addr_o, .rvalid_i
);

// File: tb/tb_ib_fetch_seq.sv
module tb_ib_fetch_seq;
  localparam int AW = 32, DW = 32, IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, wide = 1'b0, burst = 1'b0, gnt = 1'b0, rvalid = 1'b0;
  logic [AW-1:0] base = '0;
  logic [DW-1:0] rdata = '0;
  logic [IW-1:0] rd_idx = '0;
  logic busy, done, req, frame, aphase;
  logic [AW-1:0] addr;
  logic [DW-1:0] rd_data;

  int n_chk = 0, n_fail = 0;

  // bus model knobs and monitor tallies
  int wait_n = 0, gnt_dly = 0, step = 4;
  logic [AW-1:0] exp_base = '0, bus_addr = '0;
  int n_ten, n_aph, n_beat, n_gap, addr_err, busy_err, gnt_cnt, wcnt, ten_beats;
  logic in_run = 1'b0, req_prev = 1'b0;

  always #10 clk = ~clk;

  ib_fetch_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base), .wide_i(wide),
    .burst_i(burst), .busy_o(busy), .done_o(done), .req_o(req), .gnt_i(gnt),
    .frame_o(frame), .aphase_o(aphase), .addr_o(addr), .rvalid_i(rvalid),
    .rdata_i(rdata), .rd_idx_i(rd_idx), .rd_data_o(rd_data)
  );

  function automatic logic [DW-1:0] mem_f(input logic [AW-1:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9bdf;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // bus partner and monitor, acting on falling edges
  initial begin
    forever begin
      @(negedge clk);
      if (rvalid) begin
        n_beat++;
        ten_beats++;
        bus_addr = bus_addr + 4;
        wcnt = 0;
      end
      if (req && !req_prev) begin
        n_ten++;
        ten_beats = 0;
      end
      req_prev = req;
      if (aphase) begin
        if (addr != exp_base + AW'(step * n_aph)) addr_err++;
        bus_addr = addr;
        n_aph++;
        wcnt = 0;
      end
      if (req && !frame && ten_beats == 1) n_gap++;
      if (in_run && !busy && !done) busy_err++;
      if (req) begin
        if (gnt_cnt >= gnt_dly) gnt = 1'b1;
        gnt_cnt++;
      end else begin
        gnt = 1'b0;
        gnt_cnt = 0;
      end
      if (frame && !aphase && wcnt >= wait_n) begin
        rvalid = 1'b1;
        rdata  = mem_f(bus_addr);
      end else begin
        rvalid = 1'b0;
        rdata  = '0;
        if (frame && !aphase) wcnt++;
      end
    end
  end

  task automatic read_ent(input int i, output logic [DW-1:0] v);
    @(negedge clk);
    rd_idx = IW'(i);
    #2;
    v = rd_data;
  endtask

  task automatic run_fetch(input logic w, input logic b, input logic [AW-1:0] bs,
                           input int wn, input int gd, input logic restart);
    int tout;
    int exp_ten;
    logic [DW-1:0] v;
    logic [DW-1:0] pre6, pre7;
    read_ent(6, pre6);
    read_ent(7, pre7);
    wait_n = wn; gnt_dly = gd; step = b ? 8 : 4; exp_base = bs;
    n_ten = 0; n_aph = 0; n_beat = 0; n_gap = 0; addr_err = 0; busy_err = 0;
    @(negedge clk);
    wide = w; burst = b; base = bs; start = 1'b1;
    @(negedge clk);
    start = 1'b0; wide = ~w; burst = ~b; base = bs + 32'h400;
    in_run = 1'b1;
    check(busy == 1'b1, "R9 busy after start", {31'b0, busy}, 1);
    if (restart) begin
      repeat (5) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    tout = 0;
    while (!done && tout < 2000) begin
      @(negedge clk);
      tout++;
    end
    in_run = 1'b0;
    check(done == 1'b1, "R9 done seen", {31'b0, done}, 1);
    check(busy == 1'b0, "R9 busy low at done", {31'b0, busy}, 0);
    @(negedge clk);
    check(done == 1'b0, "R9 done one cycle", {31'b0, done}, 0);
    check(busy_err == 0, "R9 busy continuous", busy_err, 0);
    exp_ten = w ? 4 : 3;
    check(n_ten == exp_ten, w ? "R3 wide tenures" : "R5 narrow tenures", n_ten, exp_ten);
    check(n_beat == 2 * exp_ten, "R2 two beats per tenure", n_beat, 2 * exp_ten);
    check(addr_err == 0, restart ? "R10 restart ignored" : "R8 address sequence",
          addr_err, 0);
    if (b) begin
      check(n_aph == exp_ten, "R7 one address phase per tenure", n_aph, exp_ten);
      check(n_gap == 0, "R7 frame held in burst", n_gap, 0);
    end else begin
      check(n_aph == 2 * exp_ten, "R6 address phase per beat", n_aph, 2 * exp_ten);
      check(n_gap == exp_ten, "R6 one frame gap per tenure", n_gap, exp_ten);
    end
    for (int i = 0; i < (w ? 7 : 6); i++) begin
      read_ent(i, v);
      check(v == mem_f(bs + AW'(4 * i)), w ? "R3 stored word" : "R5 stored word",
            v, mem_f(bs + AW'(4 * i)));
    end
    read_ent(7, v);
    check(v == pre7, w ? "R4 surplus read dropped" : "R5 entry 7 untouched", v, pre7);
    if (!w) begin
      read_ent(6, v);
      check(v == pre6, "R5 entry 6 untouched", v, pre6);
    end
  endtask

  task automatic test_reset();
    logic [DW-1:0] v;
    check({busy, done, req, frame, aphase} == 5'b0, "R1 idle outputs",
          {27'b0, busy, done, req, frame, aphase}, 0);
    for (int i = 0; i < 8; i++) begin
      read_ent(i, v);
      check(v == '0, "R11 R1 entry zero", v, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    run_fetch(1'b1, 1'b0, 32'h0000_1000, 0, 0, 1'b0);
    run_fetch(1'b1, 1'b1, 32'h0002_3a40, 1, 2, 1'b0);
    run_fetch(1'b0, 1'b0, 32'h0000_8f0c, 2, 1, 1'b0);
    run_fetch(1'b0, 1'b1, 32'h00ab_0010, 0, 3, 1'b0);
    run_fetch(1'b1, 1'b0, 32'h0004_0004, 1, 0, 1'b1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule